// File: doc/BRIEF.md
# I2C Master Serial-Clock Rate Generator

This block produces the serial clock level for an I2C master, together with a one-cycle strobe at every half period that a protocol sequencer can use to place its start, stop and data events. A 7-bit down-counter is stepped by a tick-enable input that pulses twice per instruction cycle. Each time the counter is at zero when a tick arrives, the clock level flips and the counter reloads. One full clock period therefore spans two counter rollovers: f_scl = f_tick / (2 × (reload + 1)). For example, a reload of 0x18 with a 20 MHz tick gives 400 kHz, and a reload of 0x63 gives 100 kHz.

A start pulse, raised when software writes a byte to the transmit buffer, loads the counter from the low seven bits of an 8-bit reload register and starts counting with no further command. A done pulse at the end of the data bits and acknowledge stops counting, and the clock stays at whatever level it had. A reload of zero is rejected: the generator does not start and raises an error flag. Two instances on one system clock run at independent rates, each set only by its own reload register.

Top module: `scl_baud_gen`

## Requirements
- R1: Only bits [6:0] of `reload_reg_i` set the rate. Bit 7 has no effect on timing or on the zero check.
- R2: A start pulse with a nonzero reload R loads the counter and starts counting. With a tick on every cycle, the first flip of `scl_o` comes exactly R+1 clock edges after the edge that captured the start.
- R3: The counter moves only on cycles where `tick_en_i` is high. With a tick every d cycles, consecutive flips of `scl_o` are (R+1)·d cycles apart.
- R4: One full `scl_o` period is two counter rollovers, which is 2·(R+1) ticks.
- R5: A done pulse with no start in the same cycle stops counting. `scl_o` keeps its present level, and no `half_tick_o` appears until the next start.
- R6: A start with reload bits [6:0] equal to zero sets `cfg_err_o` and leaves the generator stopped, with `scl_o` unchanged. The next start with a nonzero reload clears `cfg_err_o`.
- R7: Two instances sharing clock and tick run at the same time, each at the rate set by its own reload value.
- R8: A reload value changed while running is used from the next rollover on. The count already in progress is not changed.
- R9: `half_tick_o` is high for exactly the cycles in which `scl_o` has just flipped, and never otherwise.
- R10: After reset, `scl_o` is 1, `half_tick_o` is 0, `cfg_err_o` is 0, and the generator is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Count enable, pulses twice per instruction cycle |
| reload_reg_i | input | 8 | Reload register; bits [6:0] are the reload value |
| start_i | input | 1 | Pulse on transmit-buffer write; loads the counter and starts |
| done_i | input | 1 | Pulse at the end of data bits plus acknowledge; stops counting |
| scl_o | output | 1 | Serial clock level |
| half_tick_o | output | 1 | One-cycle strobe at each flip of `scl_o` |
| cfg_err_o | output | 1 | Set when a start was attempted with a zero reload |

## Verification
The checker verifies on every cycle that the clock flips exactly when the half-period strobe is high, and that a strobe only follows a cycle with a tick. It also checks that a done pulse freezes the clock level and that a start with a zero reload raises the error flag. The exact intervals cannot be seen by those properties and are left to the bench scenarios: the first flip after start, the spacing under sparse ticks, a reload changed in mid-run, the two-instance rates and the masking of bit 7. The bench sweeps every legal reload value.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  localparam int unsigned RLD_W_DEF = 7;
  localparam int unsigned REG_W_DEF = 8;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;
endpackage

// File: rtl/bgen_ctrl.sv
module bgen_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic reload_ok_i,
  output logic run_o,
  output logic load_o,
  output logic err_o
);
  import bgen_pkg::*;

  gen_state_e state_q, state_d;
  logic       err_q, err_d;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    if (start_i) begin
      if (reload_ok_i) begin
        state_d = GEN_RUN;
        err_d   = 1'b0;
      end else begin
        state_d = GEN_IDLE;
        err_d   = 1'b1;
      end
    end else if (done_i) begin
      state_d = GEN_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GEN_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign run_o  = (state_q == GEN_RUN);
  assign load_o = start_i && reload_ok_i;
  assign err_o  = err_q;
endmodule

// File: rtl/bgen_counter.sv
module bgen_counter #(
  parameter int unsigned RLD_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic [RLD_W-1:0] value_i,
  output logic             roll_o
);
  localparam logic [RLD_W-1:0] CNT_ZERO = '0;
  localparam logic [RLD_W-1:0] CNT_ONE  = {{(RLD_W-1){1'b0}}, 1'b1};

  logic [RLD_W-1:0] cnt_q, cnt_d;
  logic [RLD_W-1:0] rld_q, rld_d;
  logic [RLD_W-1:0] next_rld;
  logic             step_en;
  logic             at_zero;
  logic             cnt_en;

  assign step_en  = run_i && tick_i && !hold_i && !load_i;
  assign at_zero  = (cnt_q == CNT_ZERO);
  assign roll_o   = step_en && at_zero;
  assign next_rld = (value_i != CNT_ZERO) ? value_i : rld_q;
  assign cnt_en   = load_i || step_en;

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    if (load_i) begin
      cnt_d = value_i;
      rld_d = value_i;
    end else if (roll_o) begin
      cnt_d = next_rld;
      rld_d = next_rld;
    end else if (step_en) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end
endmodule

// File: rtl/bgen_scl.sv
module bgen_scl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic roll_i,
  output logic scl_o,
  output logic half_o
);
  logic scl_q, scl_d;
  logic half_q, half_d;

  always_comb begin
    scl_d  = roll_i ? ~scl_q : scl_q;
    half_d = roll_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      half_q <= 1'b0;
    end else begin
      scl_q  <= scl_d;
      half_q <= half_d;
    end
  end

  assign scl_o  = scl_q;
  assign half_o = half_q;
endmodule

// File: rtl/scl_baud_gen.sv
module scl_baud_gen #(
  parameter int unsigned RLD_W = bgen_pkg::RLD_W_DEF,
  parameter int unsigned REG_W = bgen_pkg::REG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic [REG_W-1:0] reload_reg_i,
  input  logic             start_i,
  input  logic             done_i,
  output logic             scl_o,
  output logic             half_tick_o,
  output logic             cfg_err_o
);
  logic [RLD_W-1:0] reload_val;
  logic             reload_ok;
  logic             run;
  logic             load;
  logic             roll;

  assign reload_val = reload_reg_i[RLD_W-1:0];
  assign reload_ok  = (reload_val != '0);

  bgen_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .done_i      (done_i),
    .reload_ok_i (reload_ok),
    .run_o       (run),
    .load_o      (load),
    .err_o       (cfg_err_o)
  );

  bgen_counter #(.RLD_W(RLD_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_en_i),
    .run_i   (run),
    .hold_i  (done_i),
    .load_i  (load),
    .value_i (reload_val),
    .roll_o  (roll)
  );

  bgen_scl u_scl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .roll_i (roll),
    .scl_o  (scl_o),
    .half_o (half_tick_o)
  );
endmodule

// File: rtl/scl_baud_gen_chk.sv
module scl_baud_gen_chk #(
  parameter int unsigned RLD_W = 7,
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_en_i,
  input logic [REG_W-1:0] reload_reg_i,
  input logic             start_i,
  input logic             done_i,
  input logic             scl_o,
  input logic             half_tick_o,
  input logic             cfg_err_o
);
  // R9
  half_means_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick_o |-> (scl_o != $past(scl_o)));

  // R9
  flip_means_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o != $past(scl_o)) |-> half_tick_o);

  // R3
  half_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick_o |-> $past(tick_en_i));

  // R6
  zero_reload_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (reload_reg_i[RLD_W-1:0] == '0)) |=> (cfg_err_o && !half_tick_o));

  // R5
  done_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> $stable(scl_o));
endmodule

bind scl_baud_gen scl_baud_gen_chk #(.RLD_W(RLD_W), .REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_en_i    (tick_en_i),
  .reload_reg_i (reload_reg_i),
  .start_i      (start_i),
  .done_i       (done_i),
  .scl_o        (scl_o),
  .half_tick_o  (half_tick_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/test_scl_baud_gen.sv
module test_scl_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic [7:0] reg_a = 8'h00, reg_b = 8'h00;
  logic       start_a = 1'b0, start_b = 1'b0;
  logic       done_a = 1'b0, done_b = 1'b0;
  logic       scl_a, half_a, err_a, scl_b, half_b, err_b;
  int         total = 0, bad = 0;
  int         div = 1, ph = 0;
  logic       pa, pb;

  always #2 clk = ~clk;

  always @(negedge clk) ph <= (ph + 1 >= div) ? 0 : ph + 1;
  assign tick = (ph == 0);

  scl_baud_gen i_scl_baud_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .reload_reg_i(reg_a),
    .start_i(start_a), .done_i(done_a),
    .scl_o(scl_a), .half_tick_o(half_a), .cfg_err_o(err_a));

  scl_baud_gen i_scl_baud_gen_b (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .reload_reg_i(reg_b),
    .start_i(start_b), .done_i(done_b),
    .scl_o(scl_b), .half_tick_o(half_b), .cfg_err_o(err_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_both(input logic [7:0] va, input logic [7:0] vb, input bit sb);
    @(negedge clk);
    reg_a = va; reg_b = vb; start_a = 1'b1; start_b = sb;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
  endtask

  task automatic stop_both();
    @(negedge clk);
    done_a = 1'b1; done_b = 1'b1;
    @(negedge clk);
    done_a = 1'b0; done_b = 1'b0;
  endtask

  // Count flips on both instances over n cycles; report first flip index of A.
  task automatic watch(input int n, output int fa, output int fb, output int first_a,
                       output int half_mis);
    fa = 0; fb = 0; first_a = -1; half_mis = 0;
    pa = scl_a; pb = scl_b;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (scl_a != pa) begin fa++; if (first_a < 0) first_a = j; end
      if (scl_b != pb) fb++;
      if ((scl_a != pa) != half_a) half_mis++;
      if ((scl_b != pb) != half_b) half_mis++;
      pa = scl_a; pb = scl_b;
    end
  endtask

  // Cycles between two consecutive flips of A.
  task automatic gap_a(output int g);
    int k;
    pa = scl_a;
    k = 0;
    while (scl_a == pa && k < 5000) begin @(negedge clk); k++; end
    pa = scl_a;
    k = 0;
    while (scl_a == pa && k < 5000) begin @(negedge clk); k++; end
    g = k;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fa, fb, fst, hm, g, n, rb;
    logic lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(scl_a == 1'b1, "R10 scl", scl_a, 1);
    chk(half_a == 1'b0, "R10 half", half_a, 0);
    chk(err_a == 1'b0, "R10 err", err_a, 0);
    watch(20, fa, fb, fst, hm);
    chk(fa == 0, "R10 idle", fa, 0);

    // R2 R4 R7 R1 R9: sweep every legal reload on A, mirrored on B with bit 7 toggling
    for (int r = 1; r < 128; r++) begin
      rb = 128 - r;
      n = 4 * (r + 1) + 1;
      start_both(8'(r), {r[0], 7'(rb)}, 1'b1);
      watch(n, fa, fb, fst, hm);
      chk(fst == r + 1, "R2 first flip", fst, r + 1);
      chk(fa == 4, "R4 two rollovers per period", fa, 4);
      chk(fb == n / (rb + 1), "R7 second instance rate", fb, n / (rb + 1));
      chk(hm == 0, "R9 strobe alignment", hm, 0);
      stop_both();
    end

    // R1 bit 7 ignored: 0x85 behaves as 0x05
    start_both(8'h85, 8'h05, 1'b1);
    watch(30, fa, fb, fst, hm);
    chk(fst == 6, "R1 bit7 first flip", fst, 6);
    chk(fa == fb, "R1 bit7 same rate", fa, fb);
    stop_both();

    // R3 sparse ticks
    for (int d = 2; d <= 3; d++) begin
      div = d;
      start_both(8'd4, 8'd0, 1'b0);
      gap_a(g);
      chk(g == 5 * d, "R3 gap with sparse ticks", g, 5 * d);
      stop_both();
      div = 1;
    end
    @(negedge clk);

    // R5 done freezes level (check both levels)
    for (int t = 0; t < 2; t++) begin
      start_both(8'd2, 8'd0, 1'b0);
      repeat (3 + 3 * t) @(negedge clk);
      lvl = scl_a;
      @(negedge clk);
      done_a = 1'b1;
      lvl = scl_a;
      @(negedge clk);
      done_a = 1'b0;
      watch(50, fa, fb, fst, hm);
      chk(fa == 0, "R5 no flips after done", fa, 0);
      chk(scl_a == lvl, "R5 level held", scl_a, lvl);
    end

    // R6 zero reload with bit 7 set
    lvl = scl_a;
    start_both(8'h80, 8'd0, 1'b0);
    chk(err_a == 1'b1, "R6 err set", err_a, 1);
    watch(40, fa, fb, fst, hm);
    chk(fa == 0, "R6 no start", fa, 0);
    chk(scl_a == lvl, "R6 scl unchanged", scl_a, lvl);
    start_both(8'd3, 8'd0, 1'b0);
    chk(err_a == 1'b0, "R6 err cleared", err_a, 0);
    stop_both();

    // R8 reload change mid-run
    start_both(8'd3, 8'd0, 1'b0);
    reg_a = 8'd6;
    watch(4, fa, fb, fst, hm);
    chk(fst == 4, "R8 current count kept", fst, 4);
    watch(7, fa, fb, fst, hm);
    chk(fst == 7, "R8 new value at next rollover", fst, 7);
    stop_both();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule